// File: doc/BRIEF.md
# Page Write Buffer and Programming Cycle Controller

This block sits between the serial bus engine of a byte-addressed non-volatile memory and its storage array. When the bus engine opens a write command, the block captures the start address. It splits that address into a fixed row and a 5-bit pointer inside the row. Data bytes that the engine hands over are then collected in a 32-byte page latch, and each latched position is marked in a per-byte valid mask.

When the command ends, the block decides whether the collected bytes are kept. Only a STOP that the bus engine reports in the slot right after an acknowledge, with at least one byte collected and no inhibited byte seen, commits the page. Any other ending throws the latch contents away.

A commit starts a self-timed programming cycle of a fixed number of clocks. During that cycle the block raises `busy`, which the bus engine uses to go silent. In the first 32 clocks of the cycle it walks the latch in ascending position order and issues one array write per clock, for valid positions only. When the cycle finishes, the mask is cleared and `busy` drops.

Top module: `pgwr_cycle_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with no stimulus, `busy` is 0 and `mem_we` is 0.
- R2: A commit happens only when all of the following hold: a STOP (`stop_evt`) arrives with `stop_in_ack_slot` high and `bus_reset` low, a command is open, no inhibited byte was seen in it, and at least one byte was latched. `busy` is then high from the next clock on. A byte strobe while no command is open is ignored.
- R3: A STOP with `stop_in_ack_slot` low, or a `bus_reset` pulse, closes the command and discards the latched bytes: no array write and no busy cycle follow.
- R4: Each accepted byte is stored at the position given by the pointer, which then advances modulo 32 while the row bits (address bits above bit 4) stay fixed. A byte sent past the row end wraps to position 0 of the same row, and a later byte to a position replaces the earlier one.
- R5: A byte strobed while `wr_inhibit` is 1 is not latched, and the command it belongs to never programs the array, even if its other bytes were accepted.
- R6: A busy cycle lasts exactly CYCLE_CLKS clocks. In busy clock k (k = 0..31) an array write to {row, k} happens if and only if position k is valid, so a commit of N bytes gives min(N, 32) writes. `mem_we` is never high outside busy.
- R7: While `busy` is high, `wr_start`, `byte_vld`, `stop_evt` and `bus_reset` are ignored. They neither open a command, nor add bytes, nor start a later commit.
- R8: A new `wr_start` clears the valid mask of any open command and reloads the row and pointer from `wr_addr`. Bytes of the abandoned command are never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Pulse: a write command opens |
| wr_addr | input | 16 | Start byte address, sampled with `wr_start` |
| byte_vld | input | 1 | Pulse: a data byte is presented |
| byte_data | input | 8 | Data byte, sampled with `byte_vld` |
| wr_inhibit | input | 1 | Write protection level, sampled with `byte_vld` |
| stop_evt | input | 1 | Pulse: a STOP was seen on the bus |
| stop_in_ack_slot | input | 1 | Qualifies `stop_evt`: STOP fell in the slot right after an ACK |
| bus_reset | input | 1 | Pulse: the bus engine abandons the current transfer |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Programming cycle in progress; bus must be ignored |

## Verification
The bench builds the block with ADDR_W = 10 and CYCLE_CLKS = 40. With these values, a full shadow of the 1024-byte array can be compared after every command, and each busy cycle ends within a few dozen clocks. These values still cover a full 32-byte page, a wrap inside a row, and a 37-byte overflow that rewrites the first five positions. The short cycle also leaves room to throw a complete command at the block in mid-cycle and confirm that it leaves no trace.

// File: rtl/pgwr_cycle_ctrl.sv
module pgwr_cycle_ctrl #(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 32,
  parameter int CYCLE_CLKS = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_start,
  input  logic [15:0]       wr_addr,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic              wr_inhibit,
  input  logic              stop_evt,
  input  logic              stop_in_ack_slot,
  input  logic              bus_reset,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              busy
);
  localparam int PTR_W = $clog2(PAGE_BYTES);
  localparam int ROW_W = ADDR_W - PTR_W;
  localparam int CNT_W = $clog2(CYCLE_CLKS + 1);
  localparam logic [CNT_W-1:0] SCAN_END = CNT_W'(PAGE_BYTES);
  localparam logic [CNT_W-1:0] LAST_CLK = CNT_W'(CYCLE_CLKS - 1);

  logic                  open_q, blocked_q, busy_q;
  logic [ROW_W-1:0]      row_q;
  logic [PTR_W-1:0]      ptr_q;
  logic [PAGE_BYTES-1:0] mask_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [7:0]            page_q [PAGE_BYTES];

  logic unused_hi;
  assign unused_hi = ^wr_addr[15:ADDR_W];

  wire idle      = !busy_q;
  wire ends_cmd  = idle && !wr_start && (stop_evt || bus_reset);
  wire take_byte = idle && !wr_start && !stop_evt && !bus_reset && byte_vld && open_q;
  wire commit    = ends_cmd && stop_evt && stop_in_ack_slot && !bus_reset &&
                   open_q && !blocked_q && (|mask_q);
  wire last_clk  = busy_q && (cnt_q == LAST_CLK);
  wire [PTR_W-1:0] scan_idx = cnt_q[PTR_W-1:0];
  wire scan_act  = busy_q && (cnt_q < SCAN_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      blocked_q <= 1'b0;
      busy_q    <= 1'b0;
      row_q     <= '0;
      ptr_q     <= '0;
      mask_q    <= '0;
      cnt_q     <= '0;
    end else if (busy_q) begin
      if (last_clk) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
        mask_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (wr_start) begin
      open_q    <= 1'b1;
      blocked_q <= 1'b0;
      mask_q    <= '0;
      row_q     <= wr_addr[ADDR_W-1:PTR_W];
      ptr_q     <= wr_addr[PTR_W-1:0];
    end else if (ends_cmd) begin
      open_q <= 1'b0;
      if (commit) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        mask_q <= '0;
      end
    end else if (take_byte) begin
      if (wr_inhibit) begin
        blocked_q <= 1'b1;
      end else begin
        mask_q[ptr_q] <= 1'b1;
        ptr_q         <= ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take_byte && !wr_inhibit) page_q[ptr_q] <= byte_data;
  end

  assign mem_we    = scan_act && mask_q[scan_idx];
  assign mem_addr  = {row_q, scan_idx};
  assign mem_wdata = page_q[scan_idx];
  assign busy      = busy_q;
endmodule

// File: rtl/pgwr_cycle_ctrl_chk.sv
module pgwr_cycle_ctrl_chk #(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 32,
  parameter int CYCLE_CLKS = 1000000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_start,
  input logic [15:0]       wr_addr,
  input logic              byte_vld,
  input logic              wr_inhibit,
  input logic              stop_evt,
  input logic              stop_in_ack_slot,
  input logic              bus_reset,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              busy
);
  localparam int PTR_W = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(CYCLE_CLKS + 2);

  logic [ADDR_W-PTR_W-1:0] row_seen;
  logic                    inh_seen;
  logic [CNT_W-1:0]        busy_cnt;
  logic                    unused_chk;
  assign unused_chk = ^{wr_addr[15:ADDR_W], wr_addr[PTR_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_seen <= '0;
      inh_seen <= 1'b0;
      busy_cnt <= '0;
    end else begin
      if (wr_start && !busy) begin
        row_seen <= wr_addr[ADDR_W-1:PTR_W];
        inh_seen <= 1'b0;
      end else if (byte_vld && wr_inhibit && !busy) begin
        inh_seen <= 1'b1;
      end
      busy_cnt <= busy ? busy_cnt + 1'b1 : '0;
    end
  end

  AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R6
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_cnt == CNT_W'(CYCLE_CLKS)); // R6
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_cnt < CNT_W'(CYCLE_CLKS)); // R6
  AST_COMMIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_evt && stop_in_ack_slot && !bus_reset)); // R2
  AST_BAD_STOP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !stop_in_ack_slot && !busy) |=> !busy); // R3
  AST_INHIBIT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && inh_seen && !busy && !wr_start) |=> !busy); // R5
  AST_ROW_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[ADDR_W-1:PTR_W] == row_seen); // R4
endmodule

bind pgwr_cycle_ctrl pgwr_cycle_ctrl_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .CYCLE_CLKS(CYCLE_CLKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
  .byte_vld(byte_vld), .wr_inhibit(wr_inhibit), .stop_evt(stop_evt),
  .stop_in_ack_slot(stop_in_ack_slot), .bus_reset(bus_reset),
  .mem_we(mem_we), .mem_addr(mem_addr), .busy(busy)
);

// File: tb/pgwr_cycle_ctrl_bench.sv
module pgwr_cycle_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 10;
  localparam int CYC = 40;
  localparam int NV  = 7;
  // {addr[9:0], count[5:0], seed[7:0], inhibit, stop_ok}
  localparam logic [25:0] VEC [NV] = '{
    {10'h045, 6'd1,  8'h11, 1'b0, 1'b1},
    {10'h0E0, 6'd32, 8'h40, 1'b0, 1'b1},
    {10'h13C, 6'd8,  8'h80, 1'b0, 1'b1},
    {10'h200, 6'd37, 8'hA0, 1'b0, 1'b1},
    {10'h065, 6'd4,  8'h22, 1'b0, 1'b0},
    {10'h0A0, 6'd3,  8'h33, 1'b1, 1'b1},
    {10'h045, 6'd2,  8'h55, 1'b0, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_start = 1'b0, byte_vld = 1'b0, wr_inhibit = 1'b0;
  logic stop_evt = 1'b0, stop_in_ack_slot = 1'b0, bus_reset = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  byte_data = '0;
  logic mem_we, busy;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;

  int nchk = 0, nfail = 0, wcount = 0;
  bit done = 1'b0;
  logic [7:0] cap [1 << AW];
  logic [7:0] expm [1 << AW];

  always #(CLK_PERIOD/2) clk = ~clk;

  pgwr_cycle_ctrl #(.ADDR_W(AW), .PAGE_BYTES(32), .CYCLE_CLKS(CYC)) u_pgwr_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .wr_inhibit(wr_inhibit),
    .stop_evt(stop_evt), .stop_in_ack_slot(stop_in_ack_slot), .bus_reset(bus_reset),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy));

  always @(negedge clk) if (mem_we) begin
    cap[mem_addr] = mem_wdata;
    wcount++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic open_cmd(input logic [9:0] a);
    wr_addr = {6'b0, a}; wr_start = 1'b1;
    @(negedge clk); wr_start = 1'b0;
  endtask

  task automatic send_bytes(input int n, input logic [7:0] seed, input bit inh);
    for (int i = 0; i < n; i++) begin
      byte_vld = 1'b1; byte_data = seed + 8'(i); wr_inhibit = inh;
      @(negedge clk);
    end
    byte_vld = 1'b0; wr_inhibit = 1'b0;
  endtask

  task automatic model(input logic [9:0] a, input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      logic [4:0] lo;
      lo = a[4:0] + 5'(i);
      expm[{a[9:5], lo}] = seed + 8'(i);
    end
  endtask

  // stop, then check busy rise, busy length and write count
  task automatic finish_cmd(input bit ok, input bit exp_commit, input int exp_wr, input string req);
    int bc;
    stop_evt = 1'b1; stop_in_ack_slot = ok;
    @(negedge clk); stop_evt = 1'b0; stop_in_ack_slot = 1'b0;
    check(busy == exp_commit, {req, " busy after stop"}, int'(busy), int'(exp_commit));
    bc = 0;
    repeat (CYC + 4) begin
      if (busy) bc++;
      @(negedge clk);
    end
    check(bc == (exp_commit ? CYC : 0), {req, " R6 busy length"}, bc, exp_commit ? CYC : 0);
    check(wcount == exp_wr, {req, " R6 write count"}, wcount, exp_wr);
  endtask

  task automatic cmp_mem(input string req);
    int bad;
    int first;
    bad = 0; first = -1;
    for (int i = 0; i < (1 << AW); i++)
      if (cap[i] !== expm[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    check(bad == 0, {req, " array contents (mismatch count / first addr)"}, bad, first);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) begin cap[i] = 8'hFF; expm[i] = 8'hFF; end
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && mem_we == 1'b0, "R1 outputs in reset", int'({busy, mem_we}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 1'b0 && mem_we == 1'b0, "R1 outputs after reset", int'({busy, mem_we}), 0);

    // table-driven commands
    for (int v = 0; v < NV; v++) begin
      logic [9:0] a; int n; logic [7:0] sd; bit inh, ok, cm;
      {a, n[5:0], sd, inh, ok} = VEC[v];
      n = n & 63;
      cm = ok && !inh && n > 0;
      wcount = 0;
      open_cmd(a);
      send_bytes(n, sd, inh);
      if (cm) model(a, n, sd);
      finish_cmd(ok, cm, cm ? ((n > 32) ? 32 : n) : 0,
                 cm ? "R2 R4 commit" : (inh ? "R5 inhibited" : "R3 bad stop"));
      cmp_mem(cm ? "R4 table vector" : "R3 R5 table vector");
    end

    // R8: restart abandons earlier bytes
    wcount = 0;
    open_cmd(10'h300); send_bytes(3, 8'h10, 1'b0);
    open_cmd(10'h320); send_bytes(2, 8'h60, 1'b0);
    model(10'h320, 2, 8'h60);
    finish_cmd(1'b1, 1'b1, 2, "R8 restart");
    cmp_mem("R8 restart");

    // R3: bus reset discards
    wcount = 0;
    open_cmd(10'h1C0); send_bytes(2, 8'h70, 1'b0);
    bus_reset = 1'b1; @(negedge clk); bus_reset = 1'b0;
    finish_cmd(1'b1, 1'b0, 0, "R3 bus reset");
    cmp_mem("R3 bus reset");

    // R5: one inhibited byte in the middle
    wcount = 0;
    open_cmd(10'h180); send_bytes(1, 8'h01, 1'b0);
    send_bytes(1, 8'h02, 1'b1); send_bytes(1, 8'h03, 1'b0);
    finish_cmd(1'b1, 1'b0, 0, "R5 mid inhibit");
    cmp_mem("R5 mid inhibit");

    // R2: byte strobe with no open command is ignored
    wcount = 0;
    send_bytes(2, 8'h99, 1'b0);
    finish_cmd(1'b1, 1'b0, 0, "R2 no open command");

    // R7: full command thrown at the block during busy
    wcount = 0;
    open_cmd(10'h2A3); send_bytes(1, 8'hC3, 1'b0);
    model(10'h2A3, 1, 8'hC3);
    stop_evt = 1'b1; stop_in_ack_slot = 1'b1;
    @(negedge clk); stop_evt = 1'b0; stop_in_ack_slot = 1'b0;
    check(busy == 1'b1, "R2 busy after good stop", int'(busy), 1);
    repeat (3) @(negedge clk);
    open_cmd(10'h3E0); send_bytes(4, 8'hE0, 1'b0);
    bus_reset = 1'b1; @(negedge clk); bus_reset = 1'b0;
    stop_evt = 1'b1; stop_in_ack_slot = 1'b1;
    @(negedge clk); stop_evt = 1'b0; stop_in_ack_slot = 1'b0;
    send_bytes(2, 8'hEE, 1'b0);
    repeat (CYC + 2) @(negedge clk);
    check(busy == 1'b0, "R7 busy over", int'(busy), 0);
    finish_cmd(1'b1, 1'b0, 1, "R7 ignored while busy");
    cmp_mem("R7 ignored while busy");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule